// File: doc/BRIEF.md
# Index Register Execution Sequencer

This block runs the multi-cycle bus work for the instructions of a small 8-bit CPU that use the 16-bit index register X and the stack pointer SP. The decoder raises `start` for one cycle with the opcode and the address of the opcode byte. From the next cycle on, the sequencer drives a byte-wide memory bus one cycle at a time. It reads the operand bytes it needs, reads and writes memory or the stack, and inserts dummy reads of `$FFFF` where the instruction has an internal step. On the final cycle it commits the new X, SP and condition flags.

The supported operations are increment, decrement, add accumulator B, load immediate, load extended, store extended, compare immediate, push and pull. Memory is modelled as combinational: `mem_rdata` must hold the byte at `bus_addr` when the clock edge that ends that cycle arrives. An opcode outside the supported set is refused: the block raises `illegal` for one cycle and changes nothing.

The controller is a step machine with six states. `S_IDLE` waits for a strobe. `S_C1` to `S_C5` are bus cycles one to five of the instruction. The transitions are:
- `S_IDLE` to `S_C1` on a strobe with a legal opcode.
- Each `S_Cn` to `S_Cn+1` while cycle n is not the instruction's last cycle.
- The last cycle (`S_C3`, `S_C4` or `S_C5`, depending on the opcode) back to `S_IDLE`.

A strobe with an illegal opcode leaves the machine in `S_IDLE`.

Top module: `ixs_seq`

## Requirements
- R1: After a synchronous reset, X is $0000, all flags are 0, SP equals the parameter SP_INIT (default $01FF) and busy is low. The flags output is {N,Z,V,C} with N at bit 3 and C at bit 0.
- R2: Increment ($08) and decrement ($09) use three bus reads, at the opcode address, the opcode address+1 and $FFFF. They change X by one and update only Z, which is set when the 16-bit result is zero.
- R3: Add accumulator B ($3A) uses the same three-read pattern as R2. It adds the unsigned 8-bit acc_b to X, with the carry out of the low byte moving into the high byte, and leaves all flags unchanged.
- R4: Load immediate ($CE) reads at the opcode address, then the high byte at +1, then the low byte at +2, over three cycles. It sets N from bit 15, sets Z when the result is zero, clears V and keeps C.
- R5: Load extended ($FE) reads over five cycles: the opcode address, the address high byte hh at +1, the address low byte ll at +2, then the data high byte at hhll and the data low byte at hhll+1. Its flag rule is the same as in R4.
- R6: Store extended ($FF) reads at the opcode address, +1 and +2. It then writes the X high byte at hhll and the X low byte at hhll+1, with bus_rw at 0 (write) only on those two cycles. It sets N and Z from X, clears V and keeps C.
- R7: Push ($3C) reads at the opcode address and +1, then writes the X low byte at SP and the X high byte at SP-1. SP ends 2 lower and the flags are unchanged.
- R8: Pull ($38) reads at the opcode address and +1, makes a dummy read at SP, then reads the high byte at SP+1 and the low byte at SP+2 into X. SP ends 2 higher and the flags are unchanged.
- R9: Compare immediate ($8C) reads at the opcode address, +1 (high byte) and +2 (low byte), then makes a dummy read at $FFFF. It computes X minus the operand without changing X. N is bit 15 of the difference, Z is set on zero, V is set on two's-complement overflow and C is set on a borrow (X below the operand, unsigned).
- R10: A strobe with any other opcode raises illegal in the following cycle only. Busy stays low, and X, SP and the flags are unchanged.
- R11: Busy is high on every bus cycle of an instruction. Done is high only on the last one. A strobe that arrives while busy is ignored.
- R12: While idle, the bus shows address $FFFF with bus_rw high (read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Decoded-opcode strobe |
| opcode | input | 8 | Opcode qualified by start |
| op_pc | input | 16 | Address of the opcode byte |
| acc_b | input | 8 | Accumulator B value |
| mem_rdata | input | 8 | Read data for the current bus address |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_wdata | output | 8 | Write data, valid when bus_rw is 0 |
| bus_rw | output | 1 | 1 = read, 0 = write |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Last cycle of the instruction |
| illegal | output | 1 | Unsupported opcode was strobed |
| x_out | output | 16 | Index register X |
| sp_out | output | 16 | Stack pointer |
| ccr_out | output | 4 | Flags {N,Z,V,C} |

## Verification
A wrong step state or a wrong latched opcode appears on `bus_addr` or `bus_rw` in the very next cycle, because every cycle's address comes from the step and the opcode. The bus trace is therefore compared cycle by cycle against an expected list. A wrongly captured operand byte shows only at commit: in X, SP or the flags one cycle after `done`, or as a wrong extended address on cycle four. Those values are checked after every instruction. The tests include sequences where the flags from one instruction must survive the next, so that a bad flag mask is caught.

// File: rtl/ixs_pkg.sv
package ixs_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_C1   = 3'd1,
        S_C2   = 3'd2,
        S_C3   = 3'd3,
        S_C4   = 3'd4,
        S_C5   = 3'd5
    } step_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam byte_t OP_INX = 8'h08;
    localparam byte_t OP_DEX = 8'h09;
    localparam byte_t OP_ABX = 8'h3A;
    localparam byte_t OP_LDI = 8'hCE;
    localparam byte_t OP_LDE = 8'hFE;
    localparam byte_t OP_STE = 8'hFF;
    localparam byte_t OP_PSH = 8'h3C;
    localparam byte_t OP_PUL = 8'h38;
    localparam byte_t OP_CPI = 8'h8C;

    localparam word_t IDLE_ADDR = '1;

    function automatic logic op_legal(byte_t op);
        case (op)
            OP_INX, OP_DEX, OP_ABX, OP_LDI, OP_LDE,
            OP_STE, OP_PSH, OP_PUL, OP_CPI: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic step_t op_last(byte_t op);
        case (op)
            OP_INX, OP_DEX, OP_ABX, OP_LDI: return S_C3;
            OP_PSH, OP_CPI:                 return S_C4;
            OP_LDE, OP_STE, OP_PUL:         return S_C5;
            default:                        return S_C1;
        endcase
    endfunction
endpackage

// File: rtl/ixs_addr.sv
module ixs_addr
    import ixs_pkg::*;
(
    input  step_t step,
    input  byte_t op,
    input  word_t pc,
    input  word_t sp,
    input  word_t x,
    input  word_t ea,
    output word_t addr,
    output logic  rw,
    output byte_t wdata
);
    always_comb begin
        addr  = IDLE_ADDR;
        rw    = 1'b1;
        wdata = '0;
        unique case (step)
            S_IDLE: addr = IDLE_ADDR;
            S_C1:   addr = pc;
            S_C2:   addr = pc + word_t'(1);
            S_C3: begin
                case (op)
                    OP_LDI, OP_LDE, OP_STE, OP_CPI: addr = pc + word_t'(2);
                    OP_PSH: begin
                        addr  = sp;
                        rw    = 1'b0;
                        wdata = x[BYTE_W-1:0];
                    end
                    OP_PUL:  addr = sp;
                    default: addr = IDLE_ADDR;
                endcase
            end
            S_C4: begin
                case (op)
                    OP_LDE: addr = ea;
                    OP_STE: begin
                        addr  = ea;
                        rw    = 1'b0;
                        wdata = x[WORD_W-1:BYTE_W];
                    end
                    OP_PSH: begin
                        addr  = sp - word_t'(1);
                        rw    = 1'b0;
                        wdata = x[WORD_W-1:BYTE_W];
                    end
                    OP_PUL:  addr = sp + word_t'(1);
                    default: addr = IDLE_ADDR;
                endcase
            end
            S_C5: begin
                case (op)
                    OP_LDE: addr = ea + word_t'(1);
                    OP_STE: begin
                        addr  = ea + word_t'(1);
                        rw    = 1'b0;
                        wdata = x[BYTE_W-1:0];
                    end
                    OP_PUL:  addr = sp + word_t'(2);
                    default: addr = IDLE_ADDR;
                endcase
            end
            default: addr = IDLE_ADDR;
        endcase
    end
endmodule

// File: rtl/ixs_alu.sv
module ixs_alu
    import ixs_pkg::*;
(
    input  byte_t op,
    input  word_t x,
    input  word_t sp,
    input  byte_t accb,
    input  byte_t t1,
    input  byte_t t2,
    input  byte_t t3,
    input  byte_t rdata,
    input  ccr_t  ccr,
    output word_t x_nxt,
    output word_t sp_nxt,
    output ccr_t  ccr_nxt
);
    word_t mword;
    word_t diff;
    word_t x_inc;
    word_t x_dec;

    assign mword = (op == OP_LDI) ? {t1, rdata} :
                   (op == OP_CPI) ? {t1, t2}    : {t3, rdata};
    assign diff  = x - mword;
    assign x_inc = x + word_t'(1);
    assign x_dec = x - word_t'(1);

    always_comb begin
        x_nxt   = x;
        sp_nxt  = sp;
        ccr_nxt = ccr;
        case (op)
            OP_INX: begin
                x_nxt     = x_inc;
                ccr_nxt.z = (x_inc == '0);
            end
            OP_DEX: begin
                x_nxt     = x_dec;
                ccr_nxt.z = (x_dec == '0);
            end
            OP_ABX: x_nxt = x + {{BYTE_W{1'b0}}, accb};
            OP_LDI, OP_LDE: begin
                x_nxt     = mword;
                ccr_nxt.n = mword[WORD_W-1];
                ccr_nxt.z = (mword == '0);
                ccr_nxt.v = 1'b0;
            end
            OP_STE: begin
                ccr_nxt.n = x[WORD_W-1];
                ccr_nxt.z = (x == '0);
                ccr_nxt.v = 1'b0;
            end
            OP_PSH: sp_nxt = sp - word_t'(2);
            OP_PUL: begin
                x_nxt  = mword;
                sp_nxt = sp + word_t'(2);
            end
            OP_CPI: begin
                ccr_nxt.n = diff[WORD_W-1];
                ccr_nxt.z = (diff == '0);
                ccr_nxt.v = (x[WORD_W-1] & ~mword[WORD_W-1] & ~diff[WORD_W-1]) |
                            (~x[WORD_W-1] & mword[WORD_W-1] & diff[WORD_W-1]);
                ccr_nxt.c = (x < mword);
            end
            default: x_nxt = x;
        endcase
    end
endmodule

// File: rtl/ixs_seq.sv
module ixs_seq
    import ixs_pkg::*;
#(
    parameter word_t SP_INIT = 16'h01FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [15:0] op_pc,
    input  logic [7:0]  acc_b,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_rw,
    output logic        busy,
    output logic        done,
    output logic        illegal,
    output logic [15:0] x_out,
    output logic [15:0] sp_out,
    output logic [3:0]  ccr_out
);
    step_t st, st_nxt;
    byte_t op_q, t1, t2, t3;
    word_t pc_q, x_q, sp_q, x_nxt, sp_nxt;
    ccr_t  ccr_q, ccr_nxt;
    logic  illegal_q;
    logic  accept, last;

    assign accept = (st == S_IDLE) && start && op_legal(opcode);
    assign last   = (st != S_IDLE) && (st == op_last(op_q));

    always_comb begin
        unique case (st)
            S_IDLE:  st_nxt = accept ? S_C1 : S_IDLE;
            S_C1:    st_nxt = last ? S_IDLE : S_C2;
            S_C2:    st_nxt = last ? S_IDLE : S_C3;
            S_C3:    st_nxt = last ? S_IDLE : S_C4;
            S_C4:    st_nxt = last ? S_IDLE : S_C5;
            S_C5:    st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= '0;
            pc_q      <= '0;
            t1        <= '0;
            t2        <= '0;
            t3        <= '0;
            x_q       <= '0;
            sp_q      <= SP_INIT;
            ccr_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= (st == S_IDLE) && start && !op_legal(opcode);
            if (accept) begin
                op_q <= opcode;
                pc_q <= op_pc;
            end
            if (st == S_C2) t1 <= mem_rdata;
            if (st == S_C3) t2 <= mem_rdata;
            if (st == S_C4) t3 <= mem_rdata;
            if (last) begin
                x_q   <= x_nxt;
                sp_q  <= sp_nxt;
                ccr_q <= ccr_nxt;
            end
        end
    end

    ixs_addr i_addr (
        .step  (st),
        .op    (op_q),
        .pc    (pc_q),
        .sp    (sp_q),
        .x     (x_q),
        .ea    ({t1, t2}),
        .addr  (bus_addr),
        .rw    (bus_rw),
        .wdata (bus_wdata)
    );

    ixs_alu i_alu (
        .op      (op_q),
        .x       (x_q),
        .sp      (sp_q),
        .accb    (acc_b),
        .t1      (t1),
        .t2      (t2),
        .t3      (t3),
        .rdata   (mem_rdata),
        .ccr     (ccr_q),
        .x_nxt   (x_nxt),
        .sp_nxt  (sp_nxt),
        .ccr_nxt (ccr_nxt)
    );

    always_comb begin
        busy    = (st != S_IDLE);
        done    = last;
        illegal = illegal_q;
        x_out   = x_q;
        sp_out  = sp_q;
        ccr_out = ccr_q;
    end
endmodule

// File: rtl/ixs_seq_chk.sv
module ixs_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic [15:0] bus_addr,
    input logic        bus_rw,
    input logic [15:0] x_out,
    input logic [15:0] sp_out
);
    // R11: done marks a bus cycle of an instruction
    a_r11_done_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R11: the machine goes idle after its last cycle
    a_r11_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10: a refused opcode never starts bus activity
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy);

    // R12: idle bus parks on the all-ones address as a read
    a_r12_idle_bus: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_addr == 16'hFFFF && bus_rw));

    // R7 / R8: SP only ever moves by two
    a_r7_sp_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sp_out != $past(sp_out)) |->
        (sp_out == $past(sp_out) + 16'd2 || sp_out == $past(sp_out) - 16'd2));

    // R11: X changes only on the edge that ends a last cycle
    a_r11_x_commit: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && x_out != $past(x_out)) |-> $past(done));
endmodule

bind ixs_seq ixs_seq_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .bus_addr (bus_addr),
    .bus_rw   (bus_rw),
    .x_out    (x_out),
    .sp_out   (sp_out)
);

// File: tb/test_ixs_seq.sv
module test_ixs_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] op_pc = 16'h0000;
    logic [7:0]  acc_b = 8'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rw;
    logic        busy, done, illegal;
    logic [15:0] x_out, sp_out;
    logic [3:0]  ccr_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] a;
        logic        rw;
        logic [7:0]  d;
        logic        last;
        string       tag;
    } item_t;

    item_t exp_q[$];
    logic [7:0] mem [logic [15:0]];
    logic [15:0] cur_x = 16'h0000;
    logic [15:0] cur_sp = 16'h01FF;

    always #5 clk = ~clk;

    ixs_seq i_ixs_seq (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .op_pc(op_pc),
        .acc_b(acc_b), .mem_rdata(mem_rdata), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rw(bus_rw), .busy(busy), .done(done),
        .illegal(illegal), .x_out(x_out), .sp_out(sp_out), .ccr_out(ccr_out)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(logic [15:0] a, logic rw, logic [7:0] d, logic last, string tag);
        item_t it;
        it.a = a; it.rw = rw; it.d = d; it.last = last; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: pops expected bus cycles and models memory
    initial begin
        forever begin
            @(negedge clk);
            if (busy) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected bus cycle", 16'd1, 16'd0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check({it.tag, " addr"}, bus_addr, it.a);
                    check({it.tag, " rw"}, {15'd0, bus_rw}, {15'd0, it.rw});
                    if (!it.rw) check({it.tag, " wdata"}, {8'd0, bus_wdata}, {8'd0, it.d});
                    check("R11 done", {15'd0, done}, {15'd0, it.last});
                end
                if (!bus_rw) mem[bus_addr] = bus_wdata;
            end
            mem_rdata = mem.exists(bus_addr) ? mem[bus_addr] : 8'h00;
        end
    end

    task automatic run(logic [7:0] op, logic [15:0] pc, int strobes,
                       logic [15:0] ex, logic [15:0] esp, logic [3:0] eccr, string tag);
        logic [15:0] ea;
        ea = {(mem.exists(pc + 16'd1) ? mem[pc + 16'd1] : 8'h00),
              (mem.exists(pc + 16'd2) ? mem[pc + 16'd2] : 8'h00)};
        push(pc, 1, 0, 0, tag);
        case (op)
            8'h08, 8'h09, 8'h3A: begin
                push(pc + 16'd1, 1, 0, 0, tag); push(16'hFFFF, 1, 0, 1, tag);
            end
            8'hCE: begin
                push(pc + 16'd1, 1, 0, 0, tag); push(pc + 16'd2, 1, 0, 1, tag);
            end
            8'hFE: begin
                push(pc + 16'd1, 1, 0, 0, tag); push(pc + 16'd2, 1, 0, 0, tag);
                push(ea, 1, 0, 0, tag); push(ea + 16'd1, 1, 0, 1, tag);
            end
            8'hFF: begin
                push(pc + 16'd1, 1, 0, 0, tag); push(pc + 16'd2, 1, 0, 0, tag);
                push(ea, 0, cur_x[15:8], 0, tag); push(ea + 16'd1, 0, cur_x[7:0], 1, tag);
            end
            8'h3C: begin
                push(pc + 16'd1, 1, 0, 0, tag);
                push(cur_sp, 0, cur_x[7:0], 0, tag); push(cur_sp - 16'd1, 0, cur_x[15:8], 1, tag);
            end
            8'h38: begin
                push(pc + 16'd1, 1, 0, 0, tag); push(cur_sp, 1, 0, 0, tag);
                push(cur_sp + 16'd1, 1, 0, 0, tag); push(cur_sp + 16'd2, 1, 0, 1, tag);
            end
            default: begin
                push(pc + 16'd1, 1, 0, 0, tag); push(pc + 16'd2, 1, 0, 0, tag);
                push(16'hFFFF, 1, 0, 1, tag);
            end
        endcase
        @(negedge clk);
        start = 1'b1; opcode = op; op_pc = pc;
        repeat (strobes) @(negedge clk);
        start = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
        #1;
        check({tag, " X"}, x_out, ex);
        check({tag, " SP"}, sp_out, esp);
        check({tag, " flags"}, {12'd0, ccr_out}, {12'd0, eccr});
        check("R12 idle addr", bus_addr, 16'hFFFF);
        check("R11 busy low", {15'd0, busy}, 16'd0);
        cur_x = ex;
        cur_sp = esp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mem[16'h8001] = 8'h00; mem[16'h8002] = 8'h00;
        mem[16'h8011] = 8'hFF; mem[16'h8012] = 8'hFF;
        mem[16'h8021] = 8'h90; mem[16'h8022] = 8'h00;
        mem[16'h9000] = 8'h12; mem[16'h9001] = 8'hF0;
        mem[16'h8031] = 8'h20; mem[16'h8032] = 8'h00;
        mem[16'h8034] = 8'h00; mem[16'h8035] = 8'h01;
        mem[16'h8037] = 8'h80; mem[16'h8038] = 8'h00;
        mem[16'h803A] = 8'h00; mem[16'h803B] = 8'h01;
        mem[16'h8041] = 8'hA0; mem[16'h8042] = 8'h00;
        mem[16'h8045] = 8'h12; mem[16'h8046] = 8'h34;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 X", x_out, 16'h0000);
        check("R1 SP", sp_out, 16'h01FF);
        check("R1 flags", {12'd0, ccr_out}, 16'h0000);
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R12 reset addr", bus_addr, 16'hFFFF);
        check("R12 reset rw", {15'd0, bus_rw}, 16'd1);

        run(8'hCE, 16'h8000, 1, 16'h0000, 16'h01FF, 4'b0100, "R4 load zero");
        run(8'h08, 16'h8003, 1, 16'h0001, 16'h01FF, 4'b0000, "R2 inc");
        run(8'hCE, 16'h8010, 1, 16'hFFFF, 16'h01FF, 4'b1000, "R4 load neg");
        run(8'h08, 16'h8013, 1, 16'h0000, 16'h01FF, 4'b1100, "R2 inc wrap Z only");
        run(8'h09, 16'h8014, 1, 16'hFFFF, 16'h01FF, 4'b1000, "R2 dec");
        run(8'hFE, 16'h8020, 1, 16'h12F0, 16'h01FF, 4'b0000, "R5 load ext");
        acc_b = 8'h20;
        run(8'h3A, 16'h8023, 1, 16'h1310, 16'h01FF, 4'b0000, "R3 add B carry");
        run(8'h8C, 16'h8030, 1, 16'h1310, 16'h01FF, 4'b1001, "R9 cmp borrow");
        run(8'hCE, 16'h8033, 1, 16'h0001, 16'h01FF, 4'b0001, "R4 load keeps C");
        run(8'hCE, 16'h8036, 1, 16'h8000, 16'h01FF, 4'b1001, "R4 load 8000");
        run(8'h8C, 16'h8039, 1, 16'h8000, 16'h01FF, 4'b0010, "R9 cmp overflow");
        run(8'hFF, 16'h8040, 1, 16'h8000, 16'h01FF, 4'b1000, "R6 store ext");
        check("R6 mem hi", {8'd0, mem[16'hA000]}, 16'h0080);
        check("R6 mem lo", {8'd0, mem[16'hA001]}, 16'h0000);
        run(8'h3C, 16'h8043, 1, 16'h8000, 16'h01FD, 4'b1000, "R7 push");
        run(8'hCE, 16'h8044, 1, 16'h1234, 16'h01FD, 4'b0000, "R4 load 1234");
        run(8'h38, 16'h8047, 1, 16'h8000, 16'h01FF, 4'b0000, "R8 pull");

        @(negedge clk);
        start = 1'b1; opcode = 8'h00; op_pc = 16'h8050;
        @(negedge clk);
        start = 1'b0;
        #1;
        check("R10 illegal pulse", {15'd0, illegal}, 16'd1);
        check("R10 no busy", {15'd0, busy}, 16'd0);
        @(negedge clk);
        #1;
        check("R10 illegal drops", {15'd0, illegal}, 16'd0);
        check("R10 X kept", x_out, 16'h8000);
        check("R10 SP kept", sp_out, 16'h01FF);
        check("R10 flags kept", {12'd0, ccr_out}, 16'h0000);

        run(8'h08, 16'h8048, 2, 16'h8001, 16'h01FF, 4'b0000, "R11 strobe while busy");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule